// File: doc/BRIEF.md
# Coalescing Store Buffer with Ordering and Completion Barriers

This block sits between a processor's store port and a memory write port. Each store carries a byte address, a 64-bit doubleword of data and an 8-bit byte-enable mask. The block takes it into one of a few pending entries and acknowledges it at once, so the core does not wait for memory. A store whose doubleword is already held by an open entry is folded into that entry: the enabled bytes are overwritten and the masks are ORed. The result is one memory write instead of two. Entries leave oldest first, one per valid/ready handshake on the memory side.

Two barrier requests share a single request line, and a select input chooses the kind. An ordering barrier is acknowledged one cycle after it is presented, whatever the buffer holds. It seals every pending entry, so a later store to the same doubleword takes a fresh entry, and that entry is written after the older ones. A completion barrier holds off further stores. It is acknowledged only after the last pending entry has been accepted by memory.

Top module: `sbuf_top`

## Requirements
- R1: The buffer holds at most DEPTH (default 4) entries. When all entries are in use and the presented store cannot be merged, st_ready is low until an entry drains.
- R2: An entry's address is the store address with its three low bits cleared, and that aligned address appears on mem_addr.
- R3: A store whose aligned address matches an open pending entry is merged into it. Bytes whose st_be bit (bit i selects data bits 8i+7..8i) is set are overwritten, and mem_be is the OR of the merged masks. Bytes never enabled read as zero on mem_data. Only one memory write results.
- R4: While a free entry exists or a merge is possible, st_ready is high independent of mem_ready, so stores are taken while memory stalls.
- R5: Entries are written to memory in allocation order, one per cycle with mem_valid and mem_ready both high. While mem_valid is high and mem_ready low, mem_addr is held.
- R6: An ordering barrier (bar_valid with bar_sync=0) is acknowledged by a one-cycle bar_ack in the next cycle, even when entries are pending. A later store to a sealed doubleword allocates a new entry, which is written after the sealed one.
- R7: A completion barrier (bar_valid with bar_sync=1) keeps st_ready low and bar_ack low while any entry is pending. bar_ack rises in the second cycle after the last entry is accepted.
- R8: A store to the head entry's doubleword in the same cycle that memory accepts the head allocates a new entry rather than merging, so both writes reach memory.
- R9: A barrier of either kind presented while the buffer is empty is acknowledged in the next cycle, and bar_ack lasts one cycle.
- R10: After reset mem_valid is low, st_ready is high and bar_ack is low.
- R11: A store accepted in the same cycle as an ordering barrier is ordered after the barrier. It does not merge into an older entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | 64 | Store data, doubleword lanes |
| st_be | input | 8 | Store byte enables |
| bar_valid | input | 1 | Barrier request, held until bar_ack |
| bar_sync | input | 1 | 1 = completion barrier, 0 = ordering barrier |
| bar_ack | output | 1 | Barrier acknowledge pulse |
| mem_valid | output | 1 | Head entry presented to memory |
| mem_ready | input | 1 | Memory accepts the head entry |
| mem_addr | output | ADDR_W | Aligned doubleword address |
| mem_data | output | 64 | Merged write data |
| mem_be | output | 8 | Merged byte mask |

## Verification
The hardest case to reach is a store that hits the head entry in the very cycle memory accepts that head. The bench reaches it by parking one entry with mem_ready low. At a single falling edge it then raises mem_ready and presents the matching store together, so both happen on the next rising edge. A store presented in the same cycle as an ordering barrier, and a completion barrier whose final drain happens one cycle before its acknowledge, are set up the same way. In each case the control inputs are lined up at one edge.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int SB_DW  = 64;
  localparam int SB_BW  = SB_DW / 8;
  localparam int SB_OFS = $clog2(SB_BW);

  // Overlay the enabled byte lanes of new_d onto old_d.
  function automatic logic [SB_DW-1:0] lane_merge(input logic [SB_DW-1:0] old_d,
                                                  input logic [SB_DW-1:0] new_d,
                                                  input logic [SB_BW-1:0] be);
    logic [SB_DW-1:0] r;
    r = old_d;
    for (int i = 0; i < SB_BW; i++) begin
      if (be[i]) r[8*i +: 8] = new_d[8*i +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl #(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [PW:0]   count,
  output logic          full,
  output logic          empty
);
  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (pop)  head <= nxt(head);
      if (push) tail <= nxt(tail);
      count <= count + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  assign full  = (count == (PW+1)'(DEPTH));
  assign empty = (count == '0);

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R5
  AST_COUNT_RANGE:  assert property (@(posedge clk) disable iff (!rst_n) count <= (PW+1)'(DEPTH)); // R1
endmodule

// File: rtl/sbuf_match.sv
module sbuf_match #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]  vld,
  input  logic [DEPTH-1:0]  open,
  input  logic [DEPTH-1:0]  excl,
  input  logic [ADDR_W-1:0] ent_addr [DEPTH],
  input  logic [ADDR_W-1:0] key,
  output logic [DEPTH-1:0]  match_vec,
  output logic              hit,
  output logic [PW-1:0]     idx
);
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cmp
    assign match_vec[gi] = vld[gi] & open[gi] & ~excl[gi] & (ent_addr[gi] == key);
  end

  always_comb begin
    hit = |match_vec;
    idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_vec[i]) idx = PW'(i);
    end
  end
endmodule

// File: rtl/sbuf_entries.sv
module sbuf_entries
  import sbuf_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [PW-1:0]     alloc_idx,
  input  logic              merge,
  input  logic [PW-1:0]     merge_idx,
  input  logic              seal_all,
  input  logic              free,
  input  logic [PW-1:0]     free_idx,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SB_DW-1:0]  in_data,
  input  logic [SB_BW-1:0]  in_be,
  output logic [DEPTH-1:0]  vld,
  output logic [DEPTH-1:0]  open,
  output logic [ADDR_W-1:0] ent_addr [DEPTH],
  output logic [SB_DW-1:0]  ent_data [DEPTH],
  output logic [SB_BW-1:0]  ent_be   [DEPTH]
);
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic              v_q, o_q;
    logic [ADDR_W-1:0] a_q;
    logic [SB_DW-1:0]  d_q;
    logic [SB_BW-1:0]  b_q;
    logic              is_alloc, is_merge, is_free;

    assign is_alloc = alloc && (alloc_idx == PW'(gi));
    assign is_merge = merge && (merge_idx == PW'(gi));
    assign is_free  = free  && (free_idx  == PW'(gi));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        o_q <= 1'b0;
        a_q <= '0;
        d_q <= '0;
        b_q <= '0;
      end else begin
        if (is_free)  v_q <= 1'b0;
        if (seal_all) o_q <= 1'b0;
        if (is_alloc) begin
          v_q <= 1'b1;
          o_q <= 1'b1;
          a_q <= in_addr;
          d_q <= lane_merge('0, in_data, in_be);
          b_q <= in_be;
        end else if (is_merge) begin
          d_q <= lane_merge(d_q, in_data, in_be);
          b_q <= b_q | in_be;
        end
      end
    end

    assign vld[gi]      = v_q;
    assign open[gi]     = o_q;
    assign ent_addr[gi] = a_q;
    assign ent_data[gi] = d_q;
    assign ent_be[gi]   = b_q;
  end

  AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n) alloc |-> !vld[alloc_idx]); // R1
  AST_MERGE_LIVE:      assert property (@(posedge clk) disable iff (!rst_n) merge |-> (vld[merge_idx] && open[merge_idx])); // R3
  AST_ONE_WRITE_KIND:  assert property (@(posedge clk) disable iff (!rst_n) !(alloc && merge)); // R3
endmodule

// File: rtl/sbuf_barrier.sv
module sbuf_barrier (
  input  logic clk,
  input  logic rst_n,
  input  logic bar_valid,
  input  logic bar_sync,
  input  logic buf_empty,
  output logic bar_ack,
  output logic take_ord,
  output logic sync_hold
);
  logic take;

  assign take      = bar_valid && !bar_ack && (!bar_sync || buf_empty);
  assign take_ord  = take && !bar_sync;
  assign sync_hold = bar_valid && bar_sync && !bar_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) bar_ack <= 1'b0;
    else        bar_ack <= take;
  end

  AST_ORD_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (bar_valid && !bar_sync && !bar_ack) |=> bar_ack); // R6
  AST_SYNC_WAITS:  assert property (@(posedge clk) disable iff (!rst_n) (bar_valid && bar_sync && !bar_ack && !buf_empty) |=> !bar_ack); // R7
  AST_ACK_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) bar_ack |=> !bar_ack); // R9
endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
  import sbuf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SB_DW-1:0]  st_data,
  input  logic [SB_BW-1:0]  st_be,
  input  logic              bar_valid,
  input  logic              bar_sync,
  output logic              bar_ack,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [SB_DW-1:0]  mem_data,
  output logic [SB_BW-1:0]  mem_be
);
  localparam int PW = $clog2(DEPTH);

  function automatic logic [ADDR_W-1:0] dw_base(input logic [ADDR_W-1:0] a);
    return a & ~ADDR_W'(SB_BW - 1);
  endfunction

  logic [PW-1:0]     head, tail, merge_idx;
  logic [PW:0]       count;
  logic              full, empty, hit, merge_ok;
  logic              drain, st_fire, do_merge, do_alloc;
  logic              take_ord, sync_hold;
  logic [DEPTH-1:0]  vld, open, excl, match_vec;
  logic [ADDR_W-1:0] st_dw;
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [SB_DW-1:0]  ent_data [DEPTH];
  logic [SB_BW-1:0]  ent_be   [DEPTH];

  assign st_dw     = dw_base(st_addr);
  assign mem_valid = !empty;
  assign drain     = mem_valid && mem_ready;
  assign excl      = drain ? (DEPTH'(1) << head) : '0;
  assign merge_ok  = hit && !take_ord;
  assign st_ready  = !sync_hold && (merge_ok || !full);
  assign st_fire   = st_valid && st_ready;
  assign do_merge  = st_fire && merge_ok;
  assign do_alloc  = st_fire && !merge_ok;

  assign mem_addr = ent_addr[head];
  assign mem_data = ent_data[head];
  assign mem_be   = ent_be[head];

  sbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push(do_alloc), .pop(drain),
    .head(head), .tail(tail), .count(count), .full(full), .empty(empty)
  );

  sbuf_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
    .vld(vld), .open(open), .excl(excl), .ent_addr(ent_addr), .key(st_dw),
    .match_vec(match_vec), .hit(hit), .idx(merge_idx)
  );

  sbuf_entries #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ent (
    .clk(clk), .rst_n(rst_n),
    .alloc(do_alloc), .alloc_idx(tail),
    .merge(do_merge), .merge_idx(merge_idx),
    .seal_all(take_ord),
    .free(drain), .free_idx(head),
    .in_addr(st_dw), .in_data(st_data), .in_be(st_be),
    .vld(vld), .open(open), .ent_addr(ent_addr), .ent_data(ent_data), .ent_be(ent_be)
  );

  sbuf_barrier u_bar (
    .clk(clk), .rst_n(rst_n), .bar_valid(bar_valid), .bar_sync(bar_sync),
    .buf_empty(empty), .bar_ack(bar_ack), .take_ord(take_ord), .sync_hold(sync_hold)
  );

  AST_FULL_STALL:     assert property (@(posedge clk) disable iff (!rst_n) (full && !merge_ok) |-> !st_ready); // R1
  AST_SINGLE_MATCH:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match_vec)); // R3
  AST_HEAD_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr))); // R5
  AST_SYNC_BLOCKS:    assert property (@(posedge clk) disable iff (!rst_n) (bar_valid && bar_sync && !bar_ack) |-> !st_ready); // R7
  AST_DRAIN_NO_MERGE: assert property (@(posedge clk) disable iff (!rst_n) (drain && do_merge) |-> (merge_idx != head)); // R8
  AST_ORD_NO_MERGE:   assert property (@(posedge clk) disable iff (!rst_n) take_ord |-> !do_merge); // R11
  AST_ALIGNED_OUT:    assert property (@(posedge clk) disable iff (!rst_n) mem_valid |-> (mem_addr[SB_OFS-1:0] == '0)); // R2
endmodule

// File: tb/tb_sbuf_top.sv
`timescale 1ns/1ps
module tb_sbuf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0, st_ready;
  logic [31:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0]  st_be = '0;
  logic        bar_valid = 1'b0, bar_sync = 1'b0, bar_ack;
  logic        mem_valid, mem_ready = 1'b0;
  logic [31:0] mem_addr;
  logic [63:0] mem_data;
  logic [7:0]  mem_be;

  int checks = 0;
  int fails  = 0;

  logic [31:0] la [64];
  logic [63:0] ld [64];
  logic [7:0]  lb [64];
  int ln = 0;

  always #2.5 clk = ~clk;

  sbuf_top dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .bar_valid(bar_valid), .bar_sync(bar_sync), .bar_ack(bar_ack),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be)
  );

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready && ln < 64) begin
      la[ln] = mem_addr;
      ld[ln] = mem_data;
      lb[ln] = mem_be;
      ln = ln + 1;
    end
  end

  typedef struct packed {
    logic [31:0] a;
    logic [7:0]  b;
    logic [63:0] d;
    logic        rdy;
  } vec_t;

  localparam vec_t STIM [7] = '{
    '{32'h0000_0100, 8'h0F, 64'hA0A1A2A3_A4A5A6A7, 1'b1},
    '{32'h0000_0104, 8'hF0, 64'hB0B1B2B3_B4B5B6B7, 1'b1},
    '{32'h0000_020B, 8'h08, 64'hC0C1C2C3_C4C5C6C7, 1'b1},
    '{32'h0000_0300, 8'hFF, 64'hD0D1D2D3_D4D5D6D7, 1'b1},
    '{32'h0000_0400, 8'h01, 64'hE0E1E2E3_E4E5E6E7, 1'b1},
    '{32'h0000_0402, 8'h04, 64'hF0F1F2F3_F4F5F6F7, 1'b1},
    '{32'h0000_0500, 8'hFF, 64'h5555_5555_5555_5555, 1'b0}
  };

  typedef struct packed {
    logic [31:0] a;
    logic [7:0]  b;
    logic [63:0] d;
  } txn_t;

  localparam txn_t EXPT [4] = '{
    '{32'h0000_0100, 8'hFF, 64'hB0B1B2B3_A4A5A6A7},
    '{32'h0000_0208, 8'h08, 64'h00000000_C4000000},
    '{32'h0000_0300, 8'hFF, 64'hD0D1D2D3_D4D5D6D7},
    '{32'h0000_0400, 8'h05, 64'h00000000_00F500E7}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [63:0] d, input logic [7:0] b);
    st_addr = a; st_data = d; st_be = b; st_valid = 1'b1;
    #1;
    while (!st_ready) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic wait_log(input int n);
    for (int g = 0; g < 100 && ln < n; g++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(mem_valid == 1'b0, "R10 mem_valid", 64'(mem_valid), 0);
    chk(st_ready == 1'b1, "R10 st_ready", 64'(st_ready), 1);
    chk(bar_ack == 1'b0, "R10 bar_ack", 64'(bar_ack), 0);
    @(negedge clk);

    // Table walk with memory stalled: R1 R3 R4
    for (int i = 0; i < 7; i++) begin
      st_addr = STIM[i].a; st_data = STIM[i].d; st_be = STIM[i].b; st_valid = 1'b1;
      #1;
      chk(st_ready == STIM[i].rdy, "R4/R1 st_ready in table", 64'(st_ready), 64'(STIM[i].rdy));
      if (st_ready) @(posedge clk);
      @(negedge clk);
      st_valid = 1'b0;
    end
    base = ln;
    chk(base == 0, "R4 no drain while stalled", 64'(base), 0);
    mem_ready = 1'b1;
    wait_log(4);
    for (int i = 0; i < 4; i++) begin
      chk(la[i] == EXPT[i].a, "R2/R5 drained addr", 64'(la[i]), 64'(EXPT[i].a));
      chk(lb[i] == EXPT[i].b, "R3 drained mask", 64'(lb[i]), 64'(EXPT[i].b));
      chk(ld[i] == EXPT[i].d, "R3 drained data", ld[i], EXPT[i].d);
    end
    chk(ln == 4, "R3 transaction count", 64'(ln), 4);
    put(32'h500, 64'h5555_5555_5555_5555, 8'hFF);
    wait_log(5);
    chk(ln == 5 && la[4] == 32'h500, "R1 store taken after drain", 64'(la[4]), 64'h500);
    mem_ready = 1'b0;

    // R5: head address held while stalled, oldest first
    base = ln;
    put(32'hA00, 64'h1, 8'h01);
    put(32'hB00, 64'h2, 8'h01);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #1;
      chk(mem_valid && mem_addr == 32'hA00, "R5 head held", 64'(mem_addr), 64'hA00);
    end
    mem_ready = 1'b1;
    wait_log(base + 2);
    chk(la[base] == 32'hA00 && la[base+1] == 32'hB00, "R5 order", 64'(la[base+1]), 64'hB00);
    mem_ready = 1'b0;

    // R6: ordering barrier with pending entry
    base = ln;
    put(32'h600, 64'h11, 8'h01);
    bar_valid = 1'b1; bar_sync = 1'b0;
    @(negedge clk); #1;
    chk(bar_ack == 1'b1, "R6 ack next cycle", 64'(bar_ack), 1);
    chk(mem_valid == 1'b1, "R6 buffer not drained", 64'(mem_valid), 1);
    bar_valid = 1'b0;
    put(32'h600, 64'h2200, 8'h02);
    mem_ready = 1'b1;
    wait_log(base + 2);
    chk(ln == base + 2, "R6 two writes", 64'(ln - base), 2);
    chk(lb[base] == 8'h01 && lb[base+1] == 8'h02, "R6 sealed order", 64'(lb[base+1]), 64'h02);
    mem_ready = 1'b0;

    // R11: store in the same cycle as an ordering barrier
    base = ln;
    put(32'h700, 64'h33, 8'h01);
    st_addr = 32'h700; st_data = 64'h4400; st_be = 8'h02; st_valid = 1'b1;
    bar_valid = 1'b1; bar_sync = 1'b0;
    #1;
    chk(st_ready == 1'b1, "R11 st_ready", 64'(st_ready), 1);
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0; bar_valid = 1'b0;
    mem_ready = 1'b1;
    wait_log(base + 2);
    chk(ln == base + 2 && lb[base] == 8'h01 && lb[base+1] == 8'h02, "R11 not merged", 64'(ln - base), 2);
    mem_ready = 1'b0;

    // R7: completion barrier waits for drain
    base = ln;
    put(32'h800, 64'h77, 8'hFF);
    bar_valid = 1'b1; bar_sync = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(bar_ack == 1'b0, "R7 no ack while pending", 64'(bar_ack), 0);
    chk(st_ready == 1'b0, "R7 stores held", 64'(st_ready), 0);
    mem_ready = 1'b1;
    @(negedge clk); #1;
    chk(ln == base + 1 && mem_valid == 1'b0, "R7 drained", 64'(ln - base), 1);
    chk(bar_ack == 1'b0, "R7 ack not yet", 64'(bar_ack), 0);
    @(negedge clk); #1;
    chk(bar_ack == 1'b1, "R7 ack after empty", 64'(bar_ack), 1);
    bar_valid = 1'b0; bar_sync = 1'b0; mem_ready = 1'b0;

    // R9: barriers on an empty buffer
    @(negedge clk);
    bar_valid = 1'b1; bar_sync = 1'b1;
    @(negedge clk); #1;
    chk(bar_ack == 1'b1, "R9 sync empty ack", 64'(bar_ack), 1);
    bar_valid = 1'b0;
    @(negedge clk); #1;
    chk(bar_ack == 1'b0, "R9 ack pulse", 64'(bar_ack), 0);
    bar_valid = 1'b1; bar_sync = 1'b0;
    @(negedge clk); #1;
    chk(bar_ack == 1'b1, "R9 ordering empty ack", 64'(bar_ack), 1);
    bar_valid = 1'b0;
    @(negedge clk);

    // R8: store to head doubleword in the cycle the head drains
    base = ln;
    put(32'h900, 64'h99, 8'h01);
    mem_ready = 1'b1;
    st_addr = 32'h904; st_data = 64'h8800; st_be = 8'h02; st_valid = 1'b1;
    #1;
    chk(st_ready == 1'b1, "R8 st_ready", 64'(st_ready), 1);
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0;
    wait_log(base + 2);
    chk(ln == base + 2, "R8 two writes", 64'(ln - base), 2);
    chk(lb[base] == 8'h01 && ld[base] == 64'h99, "R8 first write", ld[base], 64'h99);
    chk(la[base+1] == 32'h900 && lb[base+1] == 8'h02 && ld[base+1] == 64'h8800, "R8 second write", ld[base+1], 64'h8800);
    mem_ready = 1'b0;

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule